// File: doc/BRIEF.md
# Masked First-Bit Prefix Mask Generator

The block turns a source mask and an enable mask into a new destination mask. It finds the lowest enabled source bit that is set, then writes a prefix pattern around that position. Three patterns are supported: ones strictly below the first hit, ones up to and including the first hit, or a single one at the first hit. A destination bit that is not enabled, or that lies at or above the vector length, keeps its old value.

The mask is handled in fixed-width chunks, one chunk per cycle, lowest chunk first. A sticky "hit found" flag carries from each chunk into the next, so a hit in a low chunk shapes every chunk above it. The caller holds the three masks, the length and the mode steady from `start` until `done`. It receives each finished chunk on a write port that carries a write enable and the chunk index.

The controller has three states. IDLE waits for `start`, and `start` moves it to SCAN with the chunk index and the found flag cleared. SCAN emits one chunk per cycle and advances the index. After the last chunk it moves to FINISH. FINISH raises `done` for one cycle and returns to IDLE.

Top module: `prefix_mask_gen`

## Requirements
- R1: While reset is held, and after it is released with no start, `busy`, `wr_en` and `done` are 0.
- R2: Mode 0 (before-first): an active destination bit is 1 if it lies below the first active set source bit, and 0 at or above it.
- R3: Mode 1 (including-first): an active destination bit is 1 if it lies at or below the first active set source bit, and 0 above it.
- R4: Mode 2 (only-first): the active bit at the first active set source bit is 1, and every other active bit is 0.
- R5: With a zero source and every bit active, mode 0 and mode 1 give all ones and mode 2 gives all zeros.
- R6: A destination bit whose enable bit is 0 keeps its old value in every mode.
- R7: A set source bit whose enable bit is 0 is never taken as the first hit.
- R8: Bits at index `vlen` and above are inactive and keep their old value. With `vlen` = 0, the whole destination is the old value.
- R9: Bit i of each flat mask is chunk i/CHUNK_W, position i%CHUNK_W (byte i>>3, bit i&7). Chunks are written on consecutive cycles with `wr_idx` counting up from 0, and a hit in a lower chunk governs all higher chunks.
- R10: `done` is high for exactly one cycle, in the cycle after the last chunk write. A `start` pulse while busy is ignored.
- R11: Mode 3 (hold) writes every chunk back equal to the old destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled in IDLE only) |
| mode | input | 2 | 0 before-first, 1 including-first, 2 only-first, 3 hold |
| vlen | input | $clog2(MASK_W+1) | Number of body bits |
| src_mask | input | MASK_W | Source mask |
| en_mask | input | MASK_W | Enable mask |
| old_dst | input | MASK_W | Previous destination mask |
| busy | output | 1 | Operation in progress |
| wr_en | output | 1 | Chunk write enable |
| wr_idx | output | $clog2(MASK_W/CHUNK_W) | Index of the chunk being written |
| wr_data | output | CHUNK_W | New destination chunk |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that mode, length and the three masks stay unchanged from the start pulse until done. The found flag and the chunk slices are meaningful only under that assumption. The bench sets every input before raising start and changes none of them until done has been seen. The only exception is a second start pulse, which is used to probe that a restart is ignored. The table rows and directed cases put the first hit at chunk edges, at the top bit, beyond the length and under disabled bits, so the carried flag and the activity gating are both exercised.

// File: rtl/pmg_pkg.sv
package pmg_pkg;
    typedef enum logic [1:0] {
        MODE_BEFORE = 2'd0,
        MODE_INCL   = 2'd1,
        MODE_ONLY   = 2'd2,
        MODE_HOLD   = 2'd3
    } pmg_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } pmg_state_e;
endpackage

// File: rtl/pmg_chunk.sv
module pmg_chunk
    import pmg_pkg::*;
#(
    parameter int CHUNK_W = 64,
    parameter int EW      = 10
) (
    input  pmg_mode_e            mode,
    input  logic [EW-1:0]        base,
    input  logic [EW-1:0]        vlen_ext,
    input  logic                 found_in,
    input  logic [CHUNK_W-1:0]   src,
    input  logic [CHUNK_W-1:0]   en,
    input  logic [CHUNK_W-1:0]   old,
    output logic [CHUNK_W-1:0]   new_data,
    output logic [CHUNK_W-1:0]   active,
    output logic                 found_out
);
    always_comb begin
        logic          seen;
        logic          hit;
        logic          res;
        logic [EW-1:0] gidx;
        seen = found_in;
        for (int j = 0; j < CHUNK_W; j++) begin
            gidx      = base + EW'(j);
            active[j] = en[j] && (gidx < vlen_ext);
            hit       = src[j] && active[j];
            unique case (mode)
                MODE_BEFORE: res = !seen && !hit;
                MODE_INCL:   res = !seen;
                MODE_ONLY:   res = !seen && hit;
                default:     res = old[j];
            endcase
            new_data[j] = active[j] ? res : old[j];
            if (hit) seen = 1'b1;
        end
        found_out = seen;
    end
endmodule

// File: rtl/pmg_ctrl.sv
module pmg_ctrl
    import pmg_pkg::*;
#(
    parameter int NCHUNK = 4,
    parameter int IDXW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            found_next,
    output logic            busy,
    output logic            wr_en,
    output logic            done,
    output logic            found_q,
    output logic [IDXW-1:0] idx_q
);
    localparam logic [IDXW-1:0] LAST = IDXW'(NCHUNK - 1);

    pmg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SCAN;
            ST_SCAN:   if (idx_q == LAST) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            found_q <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    idx_q   <= '0;
                    found_q <= 1'b0;
                end
                ST_SCAN: begin
                    found_q <= found_next;
                    if (idx_q != LAST) idx_q <= idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy  = (state_q != ST_IDLE);
        wr_en = (state_q == ST_SCAN);
        done  = (state_q == ST_FINISH);
    end

    p_idx_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx_q != LAST) |=> (wr_en && idx_q == $past(idx_q) + 1'b1));
    p_first_chunk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (wr_en && idx_q == '0));
    p_found_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && found_q && idx_q != LAST) |=> found_q);
    p_done_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx_q == LAST) |=> (done && !wr_en));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/prefix_mask_gen.sv
module prefix_mask_gen
    import pmg_pkg::*;
#(
    parameter int MASK_W  = 256,
    parameter int CHUNK_W = 64,
    localparam int NCHUNK = MASK_W / CHUNK_W,
    localparam int IDXW   = (NCHUNK > 1) ? $clog2(NCHUNK) : 1,
    localparam int VLW    = $clog2(MASK_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         mode,
    input  logic [VLW-1:0]     vlen,
    input  logic [MASK_W-1:0]  src_mask,
    input  logic [MASK_W-1:0]  en_mask,
    input  logic [MASK_W-1:0]  old_dst,
    output logic               busy,
    output logic               wr_en,
    output logic [IDXW-1:0]    wr_idx,
    output logic [CHUNK_W-1:0] wr_data,
    output logic               done
);
    localparam int EW = VLW + 1;

    logic               found_q, found_next;
    logic [CHUNK_W-1:0] src_c, en_c, old_c, act_c;
    logic [EW-1:0]      base;
    pmg_mode_e          mode_e;

    assign mode_e = pmg_mode_e'(mode);
    assign base   = EW'(wr_idx) * EW'(CHUNK_W);
    assign src_c  = src_mask[int'(wr_idx) * CHUNK_W +: CHUNK_W];
    assign en_c   = en_mask [int'(wr_idx) * CHUNK_W +: CHUNK_W];
    assign old_c  = old_dst [int'(wr_idx) * CHUNK_W +: CHUNK_W];

    pmg_ctrl #(.NCHUNK(NCHUNK), .IDXW(IDXW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .found_next (found_next),
        .busy       (busy),
        .wr_en      (wr_en),
        .done       (done),
        .found_q    (found_q),
        .idx_q      (wr_idx)
    );

    pmg_chunk #(.CHUNK_W(CHUNK_W), .EW(EW)) u_chunk (
        .mode      (mode_e),
        .base      (base),
        .vlen_ext  (EW'(vlen)),
        .found_in  (found_q),
        .src       (src_c),
        .en        (en_c),
        .old       (old_c),
        .new_data  (wr_data),
        .active    (act_c),
        .found_out (found_next)
    );

    p_only_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_e == MODE_ONLY) |-> ($countones(wr_data & act_c) <= 1));
    p_only_after_found_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_e == MODE_ONLY && found_q) |-> ((wr_data & act_c) == '0));
    p_inactive_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (((wr_data ^ old_c) & ~act_c) == '0));
    p_hold_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_e == MODE_HOLD) |-> (wr_data == old_c));
endmodule

// File: tb/prefix_mask_gen_bench.sv
`timescale 1ns/1ps
module prefix_mask_gen_bench;
    localparam int MW = 256;
    localparam int CW = 64;
    localparam int NC = MW / CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = '0;
    logic [8:0]    vlen = '0;
    logic [MW-1:0] src_mask = '0, en_mask = '0, old_dst = '0;
    logic          busy, wr_en, done;
    logic [1:0]    wr_idx;
    logic [CW-1:0] wr_data;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    prefix_mask_gen u_prefix_mask_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .vlen(vlen),
        .src_mask(src_mask), .en_mask(en_mask), .old_dst(old_dst),
        .busy(busy), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .done(done)
    );

    typedef struct packed {
        logic [3:0] req;
        logic [1:0] md;
        logic [8:0] vl;
        logic [7:0] sb;
        logic [7:0] eb;
        logic [7:0] ob;
        logic [8:0] pos;
    } row_t;

    localparam int NROWS = 13;
    localparam row_t TBL [NROWS] = '{
        '{4'd5,  2'd0, 9'd256, 8'h00, 8'hff, 8'h00, 9'd511}, // R5 before, zero src
        '{4'd5,  2'd1, 9'd256, 8'h00, 8'hff, 8'h00, 9'd511}, // R5 including, zero src
        '{4'd5,  2'd2, 9'd256, 8'h00, 8'hff, 8'hff, 9'd511}, // R5 only, zero src
        '{4'd2,  2'd0, 9'd256, 8'ha5, 8'h5a, 8'h3c, 9'd100}, // R2 hit in chunk 1
        '{4'd3,  2'd1, 9'd256, 8'ha5, 8'h5a, 8'h3c, 9'd200}, // R3 hit in chunk 3
        '{4'd4,  2'd2, 9'd256, 8'ha5, 8'h5a, 8'h3c, 9'd37},  // R4 hit in chunk 0
        '{4'd2,  2'd0, 9'd256, 8'hff, 8'h0f, 8'hc3, 9'd3},   // R2 dense source
        '{4'd4,  2'd2, 9'd130, 8'h81, 8'he7, 8'h55, 9'd511}, // R4 hit at bit 0
        '{4'd8,  2'd1, 9'd70,  8'h00, 8'hff, 8'haa, 9'd250}, // R8 hit beyond vlen
        '{4'd11, 2'd3, 9'd256, 8'hff, 8'hff, 8'h69, 9'd511}, // R11 hold mode
        '{4'd8,  2'd2, 9'd0,   8'hff, 8'hff, 8'h96, 9'd511}, // R8 zero length
        '{4'd9,  2'd0, 9'd256, 8'h00, 8'hff, 8'h00, 9'd255}, // R9 hit at top bit
        '{4'd9,  2'd2, 9'd256, 8'h00, 8'hff, 8'h00, 9'd64}   // R9 hit at chunk edge
    };

    function automatic logic [MW-1:0] ref_dst(input logic [1:0] md, input int vl,
            input logic [MW-1:0] s, input logic [MW-1:0] e, input logic [MW-1:0] o);
        logic [MW-1:0] r;
        bit seen;
        r = o;
        seen = 0;
        for (int i = 0; i < MW; i++) begin
            if (e[i] && i < vl && md != 2'd3) begin
                case (md)
                    2'd0: r[i] = !seen && !s[i];
                    2'd1: r[i] = !seen;
                    default: r[i] = !seen && s[i];
                endcase
                if (s[i]) seen = 1;
            end
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [MW-1:0] act,
                       input logic [MW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input bit poke, output logic [MW-1:0] got,
                          output int nwr, output bit seq_ok, output bit done_ok);
        got = '0; nwr = 0; seq_ok = 1; done_ok = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 20; c++) begin
            if (wr_en) begin
                if (int'(wr_idx) != nwr) seq_ok = 0;
                got[int'(wr_idx) * CW +: CW] = wr_data;
                nwr++;
            end else if (done) begin
                done_ok = (nwr == NC);
                break;
            end
            if (poke) start = (c == 1);
            @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
        chk(!done, "R10 done single cycle", MW'(done), '0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [MW-1:0] got, exp, s, e, o;
        int nwr;
        bit sq, dn;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !wr_en && !done, "R1 in reset", {busy, wr_en, done}, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !wr_en && !done, "R1 after reset", {busy, wr_en, done}, '0);

        foreach (TBL[k]) begin
            s = {32{TBL[k].sb}};
            e = {32{TBL[k].eb}};
            o = {32{TBL[k].ob}};
            if (TBL[k].pos < 9'd256) begin
                for (int i = 0; i < int'(TBL[k].pos); i++) s[i] = 1'b0;
                s[TBL[k].pos[7:0]] = 1'b1;
                e[TBL[k].pos[7:0]] = 1'b1;
            end
            mode = TBL[k].md; vlen = TBL[k].vl;
            src_mask = s; en_mask = e; old_dst = o;
            exp = ref_dst(TBL[k].md, int'(TBL[k].vl), s, e, o);
            run_op(0, got, nwr, sq, dn);
            chk(got === exp, $sformatf("R%0d row %0d", TBL[k].req, k), got, exp);
            chk(((got ^ o) & ~e) == '0, "R6 disabled bits kept", got & ~e, o & ~e);
            chk(sq && nwr == NC, "R9 chunk order", MW'(nwr), MW'(NC));
            chk(dn, "R10 done after last chunk", MW'(dn), 1);
        end

        // R7: disabled source bits below the real hit are skipped
        s = '0; e = '1; o = {32{8'h0f}};
        s[5] = 1'b1; e[5] = 1'b0; s[130] = 1'b1;
        mode = 2'd2; vlen = 9'd256; src_mask = s; en_mask = e; old_dst = o;
        run_op(0, got, nwr, sq, dn);
        chk(got[130] == 1'b1 && got[5] == o[5] && $countones(got & e) == 1,
            "R7 disabled hit ignored", got, ref_dst(2'd2, 256, s, e, o));

        // R10: second start while busy is ignored
        s = '0; s[70] = 1'b1; e = '1; o = '0;
        mode = 2'd1; src_mask = s; en_mask = e; old_dst = o;
        run_op(1, got, nwr, sq, dn);
        chk(nwr == NC && sq && dn, "R10 restart ignored", MW'(nwr), MW'(NC));
        repeat (3) @(negedge clk);
        chk(!busy && !wr_en, "R10 idle after restart probe", MW'(busy), '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule